// File: doc/BRIEF.md
# Partitioned Byte-Wide Memory Bus Decoder

This block sits between a processor core's memory access port and two external buses. Each program fetch or data access is decoded into one of three targets: the primary SRAM on a non-multiplexed byte-wide bus, which is selected by chip enable one; a second data-only SRAM bank, which is selected by chip enable two; or the expanded multiplexed bus, which receives every access that the byte-wide window does not claim. A RAM-size setting picks an 8 KiB or 32 KiB primary device. A partition value, in 2 KiB steps, marks the low part of that device as write-protected code and the rest as writable data.

The core raises a request while the block is idle. The block captures the request, including the partition and size settings of that moment, and then runs a fixed sequence of states. In IDLE it waits for a request. In SETUP the address is driven and all strobes are high. In STROBE (byte-wide) or EXPAND (expanded bus) the strobe is active for one cycle. In HOLD the strobes are released, the address is still held, and read data is presented. The transitions are: IDLE to SETUP on an accepted request; SETUP to STROBE or EXPAND depending on the target; either strobe state to HOLD; and HOLD to IDLE. A power-fail flag sends every state to IDLE and forces the strobes inactive at once.

Top module: `membus_decoder`

## Requirements
- R1: With `ram_big`=1, data or fetch accesses to 0000h..7FFFh assert `ce1_n` low. Op codes are 0 fetch, 1 read, 2 write and 3 read. A write asserts `rw_n` low in the same cycle and drives `bd_out` with the write data.
- R2: With `ram_big`=0, only 0000h..1FFFh use `ce1_n`. Every address from 2000h up goes to the expanded bus.
- R3: An access outside the byte-wide window pulses `exp_stb` for one cycle, with `exp_addr` equal to the full address. On writes `exp_wr`=1 and `exp_wdata` carries the data. `ce1_n` and `ce2_n` stay high.
- R4: A data access (op 1, 2 or 3) with `acc_bank2`=1 and an address below 8000h asserts `ce2_n`. Fetches ignore `acc_bank2`. A data access with `acc_bank2`=1 at 8000h or above goes to the expanded bus. During a `ce2_n` cycle `exp_stb` stays 0 and `exp_addr` reads 0.
- R5: The code/data boundary is `part_sel`×2048. A write through `ce1_n` below the boundary still asserts `ce1_n` but keeps `rw_n` high. A write at or above the boundary drives `rw_n` low.
- R6: Writes through `ce2_n` are never blocked by the partition.
- R7: `ba[14]` and `ba[13]` are the inverted address bits 14 and 13. `ba[12:0]` equals address bits 12..0.
- R8: While `pfail`=1, `ce1_n`, `ce2_n` and `rw_n` are 1 and `exp_stb` is 0. A running access is abandoned, with no `rd_valid`. No request is accepted while `pfail`=1.
- R9: An accepted request gives one SETUP cycle with strobes high, then one strobe cycle, then one HOLD cycle with strobes high and `ba` unchanged. `acc_busy` is 1 throughout.
- R10: The partition, size and bank settings are captured when the request is accepted. A later change affects only the next access.
- R11: For reads and fetches, `rd_valid`=1 in the HOLD cycle. `rd_data` then holds `bd_in` (byte-wide target) or `exp_rdata` (expanded target), sampled in the strobe cycle.
- R12: After reset, all strobes are high, `acc_busy`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pfail | input | 1 | Reset/power-fail flag, forces strobes inactive |
| acc_req | input | 1 | Access request, taken when idle |
| acc_op | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| acc_addr | input | 16 | Logical address |
| acc_wdata | input | 8 | Write data |
| acc_bank2 | input | 1 | Select the second data bank |
| part_sel | input | 5 | Code/data boundary in 2 KiB steps |
| ram_big | input | 1 | 1 = 32 KiB primary SRAM, 0 = 8 KiB |
| acc_busy | output | 1 | Access in progress |
| ce1_n | output | 1 | Primary SRAM chip enable, active low |
| ce2_n | output | 1 | Data bank chip enable, active low |
| rw_n | output | 1 | SRAM write enable, active low |
| ba | output | 15 | Byte-wide address, bits 14 and 13 inverted |
| bd_out | output | 8 | Byte-wide write data |
| bd_oe | output | 1 | Byte-wide data drive enable |
| bd_in | input | 8 | Byte-wide read data |
| exp_stb | output | 1 | Expanded bus access strobe |
| exp_wr | output | 1 | Expanded bus write |
| exp_addr | output | 16 | Expanded bus address |
| exp_wdata | output | 8 | Expanded bus write data |
| exp_rdata | input | 8 | Expanded bus read data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
Accesses are issued at both edges of each window: 0000h, 1FFFh, 2000h, 7FFFh and 8000h, in both size settings. This separates the 8 KiB and 32 KiB decodes from the expanded-bus fallthrough. Bank-select accesses are repeated as fetch and as data, below and above 8000h, which separates the data-only bank from the primary SRAM and from the expanded bus. Writes on both sides of several partition values show whether the boundary is inclusive, and whether the protection is wrongly applied to the second bank. A partition change after acceptance and a power fail in mid-strobe show whether settings are captured and whether the abort releases every strobe.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        TGT_CE1 = 2'd0,
        TGT_CE2 = 2'd1,
        TGT_EXP = 2'd2
    } mbd_tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_EXPAND = 3'd3,
        ST_HOLD   = 3'd4
    } mbd_state_e;

    localparam logic [1:0] OPC_FETCH = 2'd0;
    localparam logic [1:0] OPC_WRITE = 2'd2;

    typedef struct packed {
        mbd_tgt_e tgt;
        logic     wr;
        logic     rd;
        logic     blocked;
    } mbd_dec_t;

endpackage

// File: rtl/mbd_latch.sv
module mbd_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PART_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              bank_in,
    input  logic [PART_W-1:0] part_in,
    input  logic              big_in,
    output logic [1:0]        op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              bank_q,
    output logic [PART_W-1:0] part_q,
    output logic              big_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            bank_q  <= 1'b0;
            part_q  <= '0;
            big_q   <= 1'b0;
        end else if (load) begin
            op_q    <= op_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            bank_q  <= bank_in;
            part_q  <= part_in;
            big_q   <= big_in;
        end
    end

endmodule

// File: rtl/mbd_decode.sv
module mbd_decode
    import mbd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BA_W      = 15,
    parameter int PART_W    = 5,
    parameter int STEP_LOG2 = 11,
    parameter int SMALL_LOG2 = 13
) (
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank2,
    input  logic [PART_W-1:0] part,
    input  logic              big,
    output mbd_dec_t          dec
);

    localparam int BND_W = PART_W + STEP_LOG2;
    localparam int CMP_W = (BND_W > ADDR_W) ? BND_W : ADDR_W;
    localparam logic [CMP_W-1:0] BIG_TOP   = CMP_W'(1) << BA_W;
    localparam logic [CMP_W-1:0] SMALL_TOP = CMP_W'(1) << SMALL_LOG2;

    logic [CMP_W-1:0] a_ext;
    logic [CMP_W-1:0] boundary;
    logic             in_window;
    logic             in_bank;
    logic             is_data;

    always_comb begin
        a_ext     = CMP_W'(addr);
        boundary  = CMP_W'(part) << STEP_LOG2;
        in_window = big ? (a_ext < BIG_TOP) : (a_ext < SMALL_TOP);
        in_bank   = (a_ext < BIG_TOP);
        is_data   = (op != OPC_FETCH);

        dec.wr = (op == OPC_WRITE);
        dec.rd = (op != OPC_WRITE);

        if (is_data && bank2 && in_bank) begin
            dec.tgt = TGT_CE2;
        end else if (in_window) begin
            dec.tgt = TGT_CE1;
        end else begin
            dec.tgt = TGT_EXP;
        end

        dec.blocked = dec.wr && (dec.tgt == TGT_CE1) && (a_ext < boundary);
    end

endmodule

// File: rtl/mbd_fsm.sv
module mbd_fsm
    import mbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pfail,
    input  logic       accept,
    input  mbd_tgt_e   tgt,
    output mbd_state_e state
);

    mbd_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (pfail) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (accept) state_nx = ST_SETUP;
                ST_SETUP:  state_nx = (tgt == TGT_EXP) ? ST_EXPAND : ST_STROBE;
                ST_STROBE: state_nx = ST_HOLD;
                ST_EXPAND: state_nx = ST_HOLD;
                ST_HOLD:   state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/membus_decoder.sv
module membus_decoder
    import mbd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int BA_W       = 15,
    parameter int PART_W     = 5,
    parameter int STEP_LOG2  = 11,
    parameter int SMALL_LOG2 = 13,
    parameter int INV_BITS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail,
    input  logic              acc_req,
    input  logic [1:0]        acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_bank2,
    input  logic [PART_W-1:0] part_sel,
    input  logic              ram_big,
    output logic              acc_busy,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              rw_n,
    output logic [BA_W-1:0]   ba,
    output logic [DATA_W-1:0] bd_out,
    output logic              bd_oe,
    input  logic [DATA_W-1:0] bd_in,
    output logic              exp_stb,
    output logic              exp_wr,
    output logic [ADDR_W-1:0] exp_addr,
    output logic [DATA_W-1:0] exp_wdata,
    input  logic [DATA_W-1:0] exp_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int INV_LO = BA_W - INV_BITS;

    mbd_state_e        state;
    mbd_dec_t          dec;
    logic              accept;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              bank_q;
    logic [PART_W-1:0] part_q;
    logic              big_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    assign accept = acc_req && (state == ST_IDLE) && !pfail;

    mbd_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PART_W (PART_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .op_in    (acc_op),
        .addr_in  (acc_addr),
        .wdata_in (acc_wdata),
        .bank_in  (acc_bank2),
        .part_in  (part_sel),
        .big_in   (ram_big),
        .op_q     (op_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .bank_q   (bank_q),
        .part_q   (part_q),
        .big_q    (big_q)
    );

    mbd_decode #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .PART_W     (PART_W),
        .STEP_LOG2  (STEP_LOG2),
        .SMALL_LOG2 (SMALL_LOG2)
    ) u_decode (
        .op    (op_q),
        .addr  (addr_q),
        .bank2 (bank_q),
        .part  (part_q),
        .big   (big_q),
        .dec   (dec)
    );

    mbd_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pfail  (pfail),
        .accept (accept),
        .tgt    (dec.tgt),
        .state  (state)
    );

    // Byte-wide address: the top INV_BITS lines are driven inverted
    for (genvar i = 0; i < BA_W; i++) begin : g_ba
        if (i >= INV_LO) begin : g_inv
            assign ba[i] = ~addr_q[i];
        end else begin : g_true
            assign ba[i] = addr_q[i];
        end
    end

    // Read data capture at the end of the strobe cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            if (!pfail && dec.rd &&
                (state == ST_STROBE || state == ST_EXPAND)) begin
                rd_valid_q <= 1'b1;
                rd_data_q  <= (state == ST_EXPAND) ? exp_rdata : bd_in;
            end
        end
    end

    // Output decode from the state register, gated by power fail
    always_comb begin
        logic sram_cyc;
        logic exp_cyc;
        sram_cyc  = (state == ST_STROBE) && !pfail;
        exp_cyc   = (state == ST_EXPAND) && !pfail;
        acc_busy  = (state != ST_IDLE);
        ce1_n     = !(sram_cyc && dec.tgt == TGT_CE1);
        ce2_n     = !(sram_cyc && dec.tgt == TGT_CE2);
        rw_n      = !(sram_cyc && dec.tgt != TGT_EXP && dec.wr && !dec.blocked);
        bd_oe     = !rw_n;
        bd_out    = wdata_q;
        exp_stb   = exp_cyc;
        exp_wr    = exp_cyc && dec.wr;
        exp_addr  = (dec.tgt == TGT_EXP) ? addr_q : '0;
        exp_wdata = (exp_cyc && dec.wr) ? wdata_q : '0;
        rd_valid  = rd_valid_q;
        rd_data   = rd_data_q;
    end

endmodule

// File: rtl/mbd_checker.sv
module mbd_checker #(
    parameter int BA_W = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pfail,
    input logic            acc_busy,
    input logic            ce1_n,
    input logic            ce2_n,
    input logic            rw_n,
    input logic            exp_stb,
    input logic [BA_W-1:0] ba
);

    a_r8_pfail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pfail |-> (ce1_n && ce2_n && rw_n && !exp_stb));

    a_r4_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2_n |-> (ce1_n && !exp_stb));

    a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> (!ce1_n || !ce2_n));

    a_r9_one_strobe_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n || !ce2_n) |=> (ce1_n && ce2_n));

    a_r9_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce1_n) |-> $stable(ba));

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n || !ce2_n) |=> $stable(ba));

    a_r9_busy_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n || !ce2_n || exp_stb) |-> acc_busy);

endmodule

bind membus_decoder mbd_checker #(.BA_W(BA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfail    (pfail),
    .acc_busy (acc_busy),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .rw_n     (rw_n),
    .exp_stb  (exp_stb),
    .ba       (ba)
);

// File: tb/membus_decoder_tb_top.sv
module membus_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfail = 1'b0;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_op = 2'd0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        acc_bank2 = 1'b0;
    logic [4:0]  part_sel = '0;
    logic        ram_big = 1'b1;
    logic        acc_busy, ce1_n, ce2_n, rw_n, bd_oe, exp_stb, exp_wr, rd_valid;
    logic [14:0] ba;
    logic [7:0]  bd_out, bd_in, exp_wdata, exp_rdata, rd_data;
    logic [15:0] exp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int          tgt;
        bit          rw_low;
        logic [14:0] ba;
        logic [15:0] eaddr;
        bit          ewr;
        logic [7:0]  wd;
        string       rq;
    } item_t;

    item_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bd_in     = ba[7:0] ^ 8'h5A;
    assign exp_rdata = exp_addr[7:0] ^ 8'hC3;

    membus_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .pfail(pfail), .acc_req(acc_req),
        .acc_op(acc_op), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_bank2(acc_bank2), .part_sel(part_sel), .ram_big(ram_big),
        .acc_busy(acc_busy), .ce1_n(ce1_n), .ce2_n(ce2_n), .rw_n(rw_n),
        .ba(ba), .bd_out(bd_out), .bd_oe(bd_oe), .bd_in(bd_in),
        .exp_stb(exp_stb), .exp_wr(exp_wr), .exp_addr(exp_addr),
        .exp_wdata(exp_wdata), .exp_rdata(exp_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    function automatic logic [14:0] ba_of(input logic [15:0] a);
        return {~a[14], ~a[13], a[12:0]};
    endfunction

    // Independent model: 0 = enable one, 1 = enable two, 2 = expanded bus
    function automatic void model(input logic [1:0] op, input logic [15:0] a,
                                  input bit bank, input logic [4:0] part,
                                  input bit big, output int tgt, output bit blk);
        bit data_acc;
        bit win;
        data_acc = (op != 2'd0);
        win = big ? (a < 16'h8000) : (a < 16'h2000);
        if (data_acc && bank && a < 16'h8000) tgt = 1;
        else if (win)                         tgt = 0;
        else                                  tgt = 2;
        blk = (op == 2'd2) && (tgt == 0) && ({1'b0, a} < {part, 11'b0});
    endfunction

    // Monitor: every strobe cycle is compared with the next expected item
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (!ce1_n || !ce2_n || exp_stb)) begin
                if (expq.size() == 0) begin
                    check("R9", "unexpected strobe", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    check(it.rq, "ce1_n", 32'(ce1_n), 32'(it.tgt != 0));
                    check(it.rq, "ce2_n", 32'(ce2_n), 32'(it.tgt != 1));
                    check(it.rq, "exp_stb", 32'(exp_stb), 32'(it.tgt == 2));
                    check(it.rq, "rw_n", 32'(rw_n), 32'(!it.rw_low));
                    if (it.tgt != 2) begin
                        check(it.rq, "ba", 32'(ba), 32'(it.ba));
                        check(it.rq, "exp_addr quiet", 32'(exp_addr), 32'd0);
                        if (it.rw_low) check(it.rq, "bd_out", 32'(bd_out), 32'(it.wd));
                    end else begin
                        check(it.rq, "exp_addr", 32'(exp_addr), 32'(it.eaddr));
                        check(it.rq, "exp_wr", 32'(exp_wr), 32'(it.ewr));
                        if (it.ewr) check(it.rq, "exp_wdata", 32'(exp_wdata), 32'(it.wd));
                    end
                end
            end
        end
    end

    // Driver: one access; part_late is applied after acceptance (R10)
    task automatic access(input logic [1:0] op, input logic [15:0] a,
                          input bit bank, input logic [4:0] part, input bit big,
                          input logic [7:0] wd, input logic [4:0] part_late,
                          input string rq);
        item_t it;
        int    tgt;
        bit    blk;
        model(op, a, bank, part, big, tgt, blk);
        it.tgt = tgt; it.rw_low = (op == 2'd2) && (tgt != 2) && !blk;
        it.ba = ba_of(a); it.eaddr = a; it.ewr = (op == 2'd2); it.wd = wd;
        it.rq = rq;
        expq.push_back(it);
        @(negedge clk);
        acc_req = 1'b1; acc_op = op; acc_addr = a; acc_bank2 = bank;
        part_sel = part; ram_big = big; acc_wdata = wd;
        @(negedge clk);
        acc_req = 1'b0; part_sel = part_late; acc_addr = ~a; ram_big = ~big;
        acc_bank2 = ~bank;
        check("R9", "setup ce1_n", 32'(ce1_n), 32'd1);
        check("R9", "setup busy", 32'(acc_busy), 32'd1);
        @(negedge clk);
        @(negedge clk);
        check("R9", "hold ce1_n", 32'(ce1_n & ce2_n & rw_n), 32'd1);
        check("R9", "hold ba", 32'(ba), 32'(ba_of(a)));
        check("R11", "rd_valid", 32'(rd_valid), 32'(op != 2'd2));
        if (op != 2'd2)
            check("R11", "rd_data", 32'(rd_data),
                  32'((tgt == 2) ? (a[7:0] ^ 8'hC3) : (ba_of(a)[7:0] ^ 8'h5A)));
        @(negedge clk);
        check("R9", "idle busy", 32'(acc_busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "reset strobes", 32'({ce1_n, ce2_n, rw_n, exp_stb}), 32'b1110);
        check("R12", "reset busy", 32'({acc_busy, rd_valid}), 32'd0);
        rst_n = 1'b1;

        // R1: 32k window
        access(2'd1, 16'h0000, 0, 5'd0, 1, 8'h00, 5'd0, "R1");
        access(2'd1, 16'h7FFF, 0, 5'd0, 1, 8'h00, 5'd0, "R1");
        access(2'd0, 16'h4321, 0, 5'd0, 1, 8'h00, 5'd0, "R1");
        access(2'd2, 16'h7000, 0, 5'd0, 1, 8'hA5, 5'd0, "R1");
        access(2'd3, 16'h0123, 0, 5'd0, 1, 8'h00, 5'd0, "R1");
        // R3: outside the window
        access(2'd1, 16'h8000, 0, 5'd0, 1, 8'h00, 5'd0, "R3");
        access(2'd2, 16'hC123, 0, 5'd0, 1, 8'h3C, 5'd0, "R3");
        // R2: 8k window
        access(2'd1, 16'h1FFF, 0, 5'd0, 0, 8'h00, 5'd0, "R2");
        access(2'd1, 16'h2000, 0, 5'd0, 0, 8'h00, 5'd0, "R2");
        access(2'd0, 16'h7FFF, 0, 5'd0, 0, 8'h00, 5'd0, "R2");
        // R4: data bank
        access(2'd1, 16'h1234, 1, 5'd0, 1, 8'h00, 5'd0, "R4");
        access(2'd0, 16'h1234, 1, 5'd0, 1, 8'h00, 5'd0, "R4");
        access(2'd3, 16'h5555, 1, 5'd0, 0, 8'h00, 5'd0, "R4");
        access(2'd1, 16'h9000, 1, 5'd0, 1, 8'h00, 5'd0, "R4");
        // R5: partition boundary
        access(2'd2, 16'h1FFF, 0, 5'd4, 1, 8'h11, 5'd4, "R5");
        access(2'd2, 16'h2000, 0, 5'd4, 1, 8'h22, 5'd4, "R5");
        access(2'd2, 16'h0000, 0, 5'd0, 1, 8'h33, 5'd0, "R5");
        access(2'd2, 16'h7FFF, 0, 5'd16, 1, 8'h44, 5'd16, "R5");
        // R6: bank two never protected
        access(2'd2, 16'h0100, 1, 5'd16, 1, 8'h55, 5'd16, "R6");
        // R7: inverted upper lines (6000h gives ba 0000h)
        access(2'd1, 16'h6000, 0, 5'd0, 1, 8'h00, 5'd0, "R7");
        access(2'd1, 16'h1ABC, 0, 5'd0, 1, 8'h00, 5'd0, "R7");
        // R10: settings changed after acceptance
        access(2'd2, 16'h1000, 0, 5'd0, 1, 8'h66, 5'd16, "R10");
        access(2'd2, 16'h1000, 0, 5'd16, 1, 8'h77, 5'd0, "R10");

        // R8: power fail in the strobe cycle
        begin
            item_t it;
            it.tgt = 0; it.rw_low = 1'b1; it.ba = ba_of(16'h3000);
            it.eaddr = 16'h3000; it.ewr = 1'b1; it.wd = 8'h99; it.rq = "R8";
            expq.push_back(it);
        end
        @(negedge clk);
        acc_req = 1'b1; acc_op = 2'd2; acc_addr = 16'h3000; acc_bank2 = 1'b0;
        part_sel = 5'd0; ram_big = 1'b1; acc_wdata = 8'h99;
        @(negedge clk);
        acc_req = 1'b0;
        @(negedge clk);
        #1 pfail = 1'b1;
        #1 check("R8", "strobes in pfail", 32'({ce1_n, ce2_n, rw_n, exp_stb}), 32'b1110);
        @(negedge clk);
        check("R8", "aborted busy", 32'(acc_busy), 32'd0);
        check("R8", "aborted rd_valid", 32'(rd_valid), 32'd0);
        acc_req = 1'b1; acc_op = 2'd1; acc_addr = 16'h0010;
        @(negedge clk);
        check("R8", "no accept in pfail", 32'(acc_busy), 32'd0);
        @(negedge clk);
        check("R8", "strobes stay high", 32'({ce1_n, ce2_n, rw_n, exp_stb}), 32'b1110);
        acc_req = 1'b0; pfail = 1'b0;
        access(2'd1, 16'h0010, 0, 5'd0, 1, 8'h00, 5'd0, "R8");

        repeat (2) @(negedge clk);
        check("R9", "scoreboard drained", 32'(expq.size()), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule